// File: doc/BRIEF.md
# Latched Inverting 4-to-16 Decoder

The block turns a 4-bit binary address into sixteen active-low select lines. At most one of those lines is low at any time. The address first goes through a level-sensitive hold stage. While latch enable is high the stage passes the live address through. When latch enable falls, the stage keeps the address it saw at that moment.

A separate active-low enable gates the outputs. When the enable is high, every select line is high. The enable never touches the stored address, so it can be toggled freely while an address is held. Driving serial data on the enable turns the block into a demultiplexer that steers the data onto the addressed line.

The outputs are combinational from the stored address and the enable, with no register after the decode. An active-low reset clears the stored address to 0. A parameter swaps the latch for a clocked flop for builds that avoid latches.

Top module: `latched_dec16_n`

## Requirements
- R1: The address is binary weighted, with bit 0 least significant. With enable low, output index k is low exactly when the stored address equals k, for every k from 0 to 15.
- R2: While latch enable is high, the stored address follows addr_i. The selected output changes with the address without waiting for a clock edge.
- R3: When latch enable goes low, the address present at that moment is kept. While latch enable stays low, changes on addr_i do not change the outputs.
- R4: While en_ni is high, all sixteen outputs are high (16'hFFFF).
- R5: No more than one output is low at any time. While en_ni is low, exactly one output is low.
- R6: en_ni has no effect on the stored address. Toggling it while latch enable is low and then driving it low shows the address held before the toggling.
- R7: In demultiplexer use, with the address held, output sel_no[addr] equals en_ni on every cycle and all other outputs stay high.
- R8: While rst_ni is low, the stored address is 0, even when latch enable is high. With en_ni low, sel_no is therefore 16'hFFFE.
- R9: A change on en_ni reaches sel_no within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; used only by the flop variant and the checker |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the stored address to 0 |
| addr_i | input | ADDR_W (4) | Binary address, bit 0 least significant |
| le_i | input | 1 | Latch enable; high = transparent, low = hold |
| en_ni | input | 1 | Active-low output enable; serial data input in demultiplexer use |
| sel_no | output | 2**ADDR_W (16) | Active-low select lines |

## Verification
The checker checks on every clock edge that at most one line is low, and exactly one while enabled. It also checks that a high enable forces all lines high, that a transparent stage selects the live address, and that held outputs stay stable while the address inputs move. Other behaviours show up only in the bench's ordered scenarios. These are the capture of the address at the falling latch enable, the fact that enable toggling leaves the held address intact, the demultiplexer data pattern, the reset value overriding a transparent latch, and same-cycle response to the enable.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic {
    HOLD_LATCH = 1'b0,
    HOLD_FLOP  = 1'b1
  } hold_e;
endpackage

// File: rtl/dec_addr_hold.sv
module dec_addr_hold #(
  parameter int             W     = 4,
  parameter dec_pkg::hold_e STYLE = dec_pkg::HOLD_LATCH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] addr_q;

  generate
    if (STYLE == dec_pkg::HOLD_LATCH) begin : g_latch
      logic unused_clk;
      assign unused_clk = clk_i;
      always_latch begin
        if (!rst_ni)   addr_q <= '0;
        else if (le_i) addr_q <= addr_i;
      end
    end else begin : g_flop
      // samples on the clock while le_i is high; one cycle later than the latch
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   addr_q <= '0;
        else if (le_i) addr_q <= addr_i;
      end
    end
  endgenerate

  assign addr_o = addr_q;
endmodule

// File: rtl/dec_onehot.sv
module dec_onehot #(
  parameter int W = 4,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] code_i,
  output logic [N-1:0] hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot_o[i] = (code_i == W'(i));
  end
endmodule

// File: rtl/dec_out_gate.sv
module dec_out_gate #(
  parameter int N = 16
) (
  input  logic         en_ni,
  input  logic [N-1:0] hot_i,
  output logic [N-1:0] sel_no
);
  always_comb begin
    if (en_ni) sel_no = '1;
    else       sel_no = ~hot_i;
  end
endmodule

// File: rtl/latched_dec16_n.sv
module latched_dec16_n #(
  parameter int             ADDR_W     = 4,
  parameter dec_pkg::hold_e HOLD_STYLE = dec_pkg::HOLD_LATCH,
  localparam int            NUM_OUT    = 1 << ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               le_i,
  input  logic               en_ni,
  output logic [NUM_OUT-1:0] sel_no
);
  logic [ADDR_W-1:0]  addr_held;
  logic [NUM_OUT-1:0] hot;

  dec_addr_hold #(.W(ADDR_W), .STYLE(HOLD_STYLE)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .addr_i (addr_i),
    .addr_o (addr_held)
  );

  dec_onehot #(.W(ADDR_W)) u_dec (
    .code_i (addr_held),
    .hot_o  (hot)
  );

  dec_out_gate #(.N(NUM_OUT)) u_gate (
    .en_ni  (en_ni),
    .hot_i  (hot),
    .sel_no (sel_no)
  );
endmodule

// File: rtl/latched_dec16_n_chk.sv
module latched_dec16_n_chk #(
  parameter int             ADDR_W     = 4,
  parameter dec_pkg::hold_e HOLD_STYLE = dec_pkg::HOLD_LATCH,
  localparam int            NUM_OUT    = 1 << ADDR_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               le_i,
  input logic               en_ni,
  input logic [NUM_OUT-1:0] sel_no
);
  localparam bit TRANSP = (HOLD_STYLE == dec_pkg::HOLD_LATCH);

  AST_AT_MOST_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~sel_no) <= 1);  // R5

  AST_ONE_LOW_WHEN_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_ni |-> $countones(~sel_no) == 1);  // R5

  AST_DISABLED_ALL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> &sel_no);  // R4

  AST_TRANSP_SELECTS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TRANSP && le_i && !en_ni) |-> !sel_no[addr_i]);  // R2

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !$past(le_i) && $stable(en_ni)) |-> $stable(sel_no));  // R3
endmodule

bind latched_dec16_n latched_dec16_n_chk #(.ADDR_W(ADDR_W), .HOLD_STYLE(HOLD_STYLE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .le_i   (le_i),
  .en_ni  (en_ni),
  .sel_no (sel_no)
);

// File: tb/latched_dec16_n_tb.sv
module latched_dec16_n_tb;
  logic        clk_i  = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = 4'd9;
  logic        le_i   = 1'b1;
  logic        en_ni  = 1'b0;
  logic [15:0] sel_no;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  latched_dec16_n u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .le_i   (le_i),
    .en_ni  (en_ni),
    .sel_no (sel_no)
  );

  // {le, en_n, addr, expected sel_no}; applied in order, state carries over
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd3,  16'hFFF7},  // R2 transparent
    {1'b1, 1'b0, 4'd12, 16'hEFFF},  // R2 follows
    {1'b0, 1'b0, 4'd12, 16'hEFFF},  // R3 capture 12
    {1'b0, 1'b0, 4'd1,  16'hEFFF},  // R3 hold
    {1'b0, 1'b1, 4'd1,  16'hFFFF},  // R4 disabled
    {1'b0, 1'b0, 4'd7,  16'hEFFF},  // R6 latch untouched
    {1'b1, 1'b1, 4'd9,  16'hFFFF},  // R4 load 9 while disabled
    {1'b1, 1'b0, 4'd9,  16'hFDFF},  // R6 load took effect
    {1'b0, 1'b0, 4'd9,  16'hFDFF},  // R3 capture 9
    {1'b0, 1'b0, 4'd0,  16'hFDFF},  // R3 hold
    {1'b1, 1'b0, 4'd15, 16'h7FFF},  // R1 top line
    {1'b1, 1'b0, 4'd0,  16'hFFFE}   // R1 bottom line
  };

  task automatic chk(input string req, input logic [15:0] exp);
    n_tests++;
    if (sel_no !== exp) begin
      n_fail++;
      $display("FAIL %s: sel_no=%h expected %h", req, sel_no, exp);
    end
  endtask

  initial begin
    #1;
    chk("R8 reset with le high", 16'hFFFE);
    @(negedge clk_i); le_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R8 after reset release", 16'hFFFE);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      le_i = VEC[v][21]; en_ni = VEC[v][20]; addr_i = VEC[v][19:16];
      #1;
      chk($sformatf("vec %0d R1 R2 R3 R4 R6", v), VEC[v][15:0]);
    end

    // R1 R5 sweep all addresses, transparent and enabled
    for (int a = 0; a < 16; a++) begin
      @(negedge clk_i);
      le_i = 1'b1; en_ni = 1'b0; addr_i = 4'(a);
      #1;
      chk($sformatf("R1 R5 addr %0d", a), ~(16'h1 << a));
    end

    // R4 sweep with enable high
    for (int a = 0; a < 16; a += 5) begin
      @(negedge clk_i);
      en_ni = 1'b1; addr_i = 4'(a);
      #1;
      chk("R4 all high", 16'hFFFF);
    end

    // R7 demux: hold address 6, stream data on en_ni
    @(negedge clk_i); addr_i = 4'd6; en_ni = 1'b1;
    @(negedge clk_i); le_i = 1'b0;
    @(negedge clk_i); addr_i = 4'd2;
    for (int b = 0; b < 8; b++) begin
      logic d;
      d = 1'(8'b1011_0010 >> b);
      @(negedge clk_i); en_ni = d;
      #1;
      chk("R7 demux bit", d ? 16'hFFFF : 16'hFFBF);
    end

    // R9 enable reaches outputs without a clock edge
    @(posedge clk_i); #3; en_ni = 1'b0;
    #1; chk("R9 enable low same cycle", 16'hFFBF);
    #2; en_ni = 1'b1;
    #1; chk("R9 enable high same cycle", 16'hFFFF);

    // R8 reset clears a held address
    @(negedge clk_i); en_ni = 1'b0; rst_ni = 1'b0;
    #1; chk("R8 reset clears held", 16'hFFFE);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #1; chk("R8 stays 0 after release", 16'hFFFE);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_tests++; n_fail++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule